// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a processor's store path and a slower memory below it. Every store goes through to memory, and the buffer absorbs those writes so that the processor does not wait for memory on each one. Each store is one word, addressed by a word address. The buffer groups stores by aligned block: a block is `BLK_WORDS` consecutive words, and its block address is the word address with the low word-select bits dropped. It has `NUM_ENT` entries. Each entry holds one block address, one data slot per word, and a per-word mask of the slots that have been written.

When merging is switched on, a store to a block that already has a pending, still-open entry is written into that entry. No new entry is taken. A run of sequential word stores therefore needs one entry and one memory transfer per block, not one per word. When merging is off, every store takes a fresh entry, so the two behaviours can be compared. Entries leave the buffer oldest first, as single block transfers that carry the word mask. The store side sees back-pressure only when every entry is taken and the incoming store cannot merge.

Both data paths use valid/ready. On the store side, a store is taken at a rising clock edge when `st_valid` and `st_ready` are both high. `st_ready` depends only on the buffer state, `merge_en` and the offered address; it does not depend on `mem_ready`. On the memory side, once `mem_valid` rises, it and the address, data and mask stay unchanged until the edge at which `mem_ready` is also high. `empty` is a plain status pin. A fence or a read miss can watch it to wait until every buffered write has left.

Top module: `store_merge_buffer`

## Requirements
- R1: Reset leaves the buffer holding nothing: `empty` is 1, `mem_valid` is 0 and `st_ready` is 1.
- R2: An accepted store to word address A goes to block address A >> 2 (with the default 4-word block) and word slot A[1:0]. While `merge_en` is 1 and an open entry holds that block, the store is written into that entry's slot and no entry is allocated. Sixteen sequential stores from a block boundary therefore produce exactly 4 memory transfers, each with mask 4'b1111.
- R3: `st_ready` is 0 exactly when all `NUM_ENT` entries are taken and the offered store does not merge. A store that merges is accepted even when the buffer is full.
- R4: With `merge_en` at 0, every accepted store allocates its own entry. After 4 stores the fifth stalls, and 16 sequential stores produce 16 transfers, each with a one-hot mask.
- R5: Transfers leave in allocation order. `mem_addr` is the block address. Word i of the block sits at `mem_data[i*32 +: 32]`. Bit i of `mem_mask` is 1 exactly when word i was written, and only those words carry meaningful data.
- R6: Once `mem_valid` is high, it and `mem_addr`, `mem_data` and `mem_mask` hold until the edge where `mem_ready` is high; the transfer completes at that edge.
- R7: The oldest entry is offered to memory once any one of three conditions holds: its mask is full, a younger entry exists, or no store was offered in the previous cycle. While it is offered it accepts no merges, and a store to its block allocates a new entry.
- R8: A store to a word slot that is already valid overwrites that slot, so the last write wins.
- R9: `empty` is 1 exactly when no entry is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | 1: stores to an open pending block merge; 0: each store takes its own entry |
| st_valid | input | 1 | A store is offered |
| st_ready | output | 1 | The buffer can take the offered store |
| st_addr | input | ADDR_W (16) | Word address of the store |
| st_data | input | DATA_W (32) | Store data |
| mem_valid | output | 1 | A block transfer is offered to memory |
| mem_ready | input | 1 | Memory takes the offered transfer |
| mem_addr | output | ADDR_W-2 (14) | Block address of the transfer |
| mem_data | output | BLK_WORDS*DATA_W (128) | Block data, word i in bits [i*32 +: 32] |
| mem_mask | output | BLK_WORDS (4) | Per-word write mask of the transfer |
| empty | output | 1 | No write is pending |

## Verification
Two events can land on the same clock edge: the oldest entry retiring to memory, and a store merging into a younger entry or allocating a new one. The bench provokes this by keeping `mem_ready` high while sixteen back-to-back sequential stores stream in. Each block completes and is offered exactly while the next block is filling. The test is judged by the recorded transfers: exactly four, in order, each with a full mask and the right words. A second case offers a store to the block that is currently on offer, and checks that the offered transfer keeps its mask while the store goes to a separate transfer behind it.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic {
    DR_OPEN = 1'b0,
    DR_HELD = 1'b1
  } drain_st_t;
endpackage

// File: rtl/wbm_slot.sv
module wbm_slot #(
  parameter int BLK_W     = 14,
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int OFS_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_i,
  input  logic                          merge_i,
  input  logic                          retire_i,
  input  logic [OFS_W-1:0]              wsel_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [BLK_W-1:0]              blk_i,
  output logic                          valid_o,
  output logic [BLK_W-1:0]              blk_o,
  output logic [BLK_WORDS-1:0]          mask_o,
  output logic [BLK_WORDS*DATA_W-1:0]   data_o
);
  logic [BLK_WORDS-1:0] sel_hot;

  always_comb begin
    sel_hot = '0;
    sel_hot[wsel_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
      blk_o   <= '0;
    end else if (alloc_i) begin
      valid_o <= 1'b1;
      mask_o  <= sel_hot;
      blk_o   <= blk_i;
    end else if (retire_i) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else if (merge_i) begin
      mask_o  <= mask_o | sel_hot;
    end
  end

  // one write port per word slot; later writes replace earlier ones
  for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[w*DATA_W +: DATA_W] <= '0;
      end else if ((alloc_i || merge_i) && sel_hot[w]) begin
        data_o[w*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/wbm_match.sv
module wbm_match #(
  parameter int NUM_ENT = 4,
  parameter int BLK_W   = 14,
  parameter int PTR_W   = 2
) (
  input  logic [NUM_ENT-1:0]       ent_valid,
  input  logic [NUM_ENT*BLK_W-1:0] ent_blk_flat,
  input  logic [PTR_W-1:0]         tail,
  input  logic [PTR_W-1:0]         head,
  input  logic                     head_locked,
  input  logic [BLK_W-1:0]         probe_blk,
  output logic                     hit,
  output logic [PTR_W-1:0]         hit_idx
);
  // search from youngest to oldest so that a newer copy of a block wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 1; k <= NUM_ENT; k++) begin
      int idx;
      idx = (int'(tail) + NUM_ENT - k) % NUM_ENT;
      if (!hit && ent_valid[idx] &&
          ent_blk_flat[idx*BLK_W +: BLK_W] == probe_blk &&
          !(head_locked && idx == int'(head))) begin
        hit     = 1'b1;
        hit_idx = PTR_W'(idx);
      end
    end
  end
endmodule

// File: rtl/wbm_drain.sv
module wbm_drain
  import wbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic have_entry,
  input  logic have_younger,
  input  logic head_full,
  input  logic st_valid,
  input  logic mem_ready,
  output logic mem_valid
);
  drain_st_t state;
  logic      idle_q;

  assign mem_valid = have_entry &&
                     (state == DR_HELD || have_younger || head_full || idle_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= DR_OPEN;
      idle_q <= 1'b1;
    end else begin
      idle_q <= !st_valid;
      if (mem_valid && mem_ready) state <= DR_OPEN;
      else if (mem_valid)         state <= DR_HELD;
    end
  end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_ENT   = 4,
  parameter int BLK_WORDS = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    merge_en,
  input  logic                                    st_valid,
  output logic                                    st_ready,
  input  logic [ADDR_W-1:0]                       st_addr,
  input  logic [DATA_W-1:0]                       st_data,
  output logic                                    mem_valid,
  input  logic                                    mem_ready,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0]     mem_addr,
  output logic [BLK_WORDS*DATA_W-1:0]             mem_data,
  output logic [BLK_WORDS-1:0]                    mem_mask,
  output logic                                    empty
);
  localparam int OFS_W  = $clog2(BLK_WORDS);
  localparam int BLK_W  = ADDR_W - OFS_W;
  localparam int LINE_W = BLK_WORDS * DATA_W;
  localparam int PTR_W  = $clog2(NUM_ENT);
  localparam int CNT_W  = $clog2(NUM_ENT + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_ENT);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_ENT - 1);

  logic [PTR_W-1:0]       head, tail;
  logic [CNT_W-1:0]       count;
  logic [NUM_ENT-1:0]     ent_valid;
  logic [BLK_W-1:0]       ent_blk  [NUM_ENT];
  logic [BLK_WORDS-1:0]   ent_mask [NUM_ENT];
  logic [LINE_W-1:0]      ent_data [NUM_ENT];
  logic [NUM_ENT*BLK_W-1:0] ent_blk_flat;

  logic [BLK_W-1:0] st_blk;
  logic [OFS_W-1:0] st_wsel;
  logic hit, merge_hit, full, fire, do_alloc, do_merge, do_retire;
  logic [PTR_W-1:0] hit_idx;

  assign st_blk    = st_addr[ADDR_W-1:OFS_W];
  assign st_wsel   = st_addr[OFS_W-1:0];
  assign full      = (count == FULL_CNT);
  assign merge_hit = merge_en && hit;
  assign st_ready  = merge_hit || !full;
  assign fire      = st_valid && st_ready;
  assign do_merge  = fire && merge_hit;
  assign do_alloc  = fire && !merge_hit;
  assign do_retire = mem_valid && mem_ready;
  assign empty     = (count == '0);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    wbm_slot #(
      .BLK_W(BLK_W), .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .OFS_W(OFS_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (do_alloc && tail == PTR_W'(i)),
      .merge_i  (do_merge && hit_idx == PTR_W'(i)),
      .retire_i (do_retire && head == PTR_W'(i)),
      .wsel_i   (st_wsel),
      .wdata_i  (st_data),
      .blk_i    (st_blk),
      .valid_o  (ent_valid[i]),
      .blk_o    (ent_blk[i]),
      .mask_o   (ent_mask[i]),
      .data_o   (ent_data[i])
    );
    assign ent_blk_flat[i*BLK_W +: BLK_W] = ent_blk[i];
  end

  wbm_match #(.NUM_ENT(NUM_ENT), .BLK_W(BLK_W), .PTR_W(PTR_W)) u_match (
    .ent_valid    (ent_valid),
    .ent_blk_flat (ent_blk_flat),
    .tail         (tail),
    .head         (head),
    .head_locked  (mem_valid),
    .probe_blk    (st_blk),
    .hit          (hit),
    .hit_idx      (hit_idx)
  );

  wbm_drain u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .have_entry   (!empty),
    .have_younger (count > CNT_W'(1)),
    .head_full    (&ent_mask[head]),
    .st_valid     (st_valid),
    .mem_ready    (mem_ready),
    .mem_valid    (mem_valid)
  );

  assign mem_addr = ent_blk[head];
  assign mem_data = ent_data[head];
  assign mem_mask = ent_mask[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (do_alloc)  tail <= ptr_next(tail);
      if (do_retire) head <= ptr_next(head);
      case ({do_alloc, do_retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
  parameter int BLK_W  = 14,
  parameter int LINE_W = 128,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [BLK_W-1:0]  mem_addr,
  input logic [LINE_W-1:0] mem_data,
  input logic [WORDS-1:0]  mem_mask,
  input logic              empty
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_data) && $stable(mem_mask));

  p_mask_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_mask != '0);

  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_valid);

  p_room_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> st_ready);

  p_store_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> !empty);
endmodule

bind store_merge_buffer wbm_checker #(
  .BLK_W(BLK_W), .LINE_W(LINE_W), .WORDS(BLK_WORDS)
) u_wbm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_mask  (mem_mask),
  .empty     (empty)
);

// File: tb/test_store_merge_buffer.sv
`timescale 1ns/1ps
module test_store_merge_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic merge_en = 1'b1;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [13:0] mem_addr;
  logic [127:0] mem_data;
  logic [3:0] mem_mask;
  logic empty;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  logic [13:0]  rec_blk  [32];
  logic [3:0]   rec_mask [32];
  logic [127:0] rec_data [32];
  int rec_n = 0;

  always #5 clk = ~clk;

  store_merge_buffer i_store_merge_buffer (
    .clk(clk), .rst_n(rst_n), .merge_en(merge_en),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask), .empty(empty)
  );

  // stimulus table: {word address, data, expected st_ready when first offered}
  localparam logic [48:0] VEC [18] = '{
    {16'h0100, 32'hA000_0100, 1'b1}, {16'h0101, 32'hA000_0101, 1'b1},
    {16'h0102, 32'hA000_0102, 1'b1}, {16'h0103, 32'hA000_0103, 1'b1},
    {16'h0104, 32'hA000_0104, 1'b1}, {16'h0105, 32'hA000_0105, 1'b1},
    {16'h0106, 32'hA000_0106, 1'b1}, {16'h0107, 32'hA000_0107, 1'b1},
    {16'h0108, 32'hA000_0108, 1'b1}, {16'h0109, 32'hA000_0109, 1'b1},
    {16'h010A, 32'hA000_010A, 1'b1}, {16'h010B, 32'hA000_010B, 1'b1},
    {16'h010C, 32'hA000_010C, 1'b1}, {16'h010D, 32'hA000_010D, 1'b1},
    {16'h010E, 32'hA000_010E, 1'b1}, {16'h010F, 32'hA000_010F, 1'b1},
    {16'h010F, 32'hBEEF_010F, 1'b1}, {16'h0110, 32'hA000_0110, 1'b0}
  };

  // record completed transfers away from the active edge
  always @(negedge clk) begin
    #4;
    if (mem_valid && mem_ready && rec_n < 32) begin
      rec_blk[rec_n]  = mem_addr;
      rec_mask[rec_n] = mem_mask;
      rec_data[rec_n] = mem_data;
      rec_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // offer one store; optionally check first ready, check a held stall, then open memory
  task automatic put(input logic [15:0] a, input logic [31:0] d, input bit chk,
                     input bit exp_rdy, input int hold, input bit rel, input string tag);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    #1;
    if (chk) check(tag, st_ready, exp_rdy);
    if (!st_ready) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk); #1;
        check({tag, " stall held"}, st_ready, 1'b0);
      end
      while (!st_ready) begin
        @(negedge clk);
        if (rel) mem_ready = 1'b1;
        #1;
      end
    end
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_empty(input string tag);
    int lim;
    lim = 0;
    @(negedge clk); #1;
    while ((!empty || mem_valid) && lim < 300) begin
      @(negedge clk); #1;
      lim++;
    end
    check({tag, " empty after drain"}, empty, 1'b1);
  endtask

  task automatic check_tx(input int k, input logic [13:0] blk, input logic [3:0] msk,
                          input logic [127:0] dat, input string tag);
    logic [127:0] wm;
    for (int w = 0; w < 4; w++) wm[w*32 +: 32] = {32{msk[w]}};
    check({tag, " block address"}, rec_blk[k], blk);
    check({tag, " mask"}, rec_mask[k], msk);
    check({tag, " data"}, rec_data[k] & wm, dat & wm);
  endtask

  initial begin
    logic [127:0] ed;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 empty", empty, 1'b1);
    check("R1 mem_valid", mem_valid, 1'b0);
    check("R1 st_ready", st_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: merge on, memory closed; R2 merging, R3 merge-when-full and stall, R8
    merge_en = 1'b1;
    rec_n = 0;
    for (int i = 0; i < 18; i++) begin
      put(VEC[i][48:33], VEC[i][32:1], 1'b1, VEC[i][0], 3, 1'b1,
          (i == 17) ? "R3 full no-merge stall" : (i == 16) ? "R3 merge accepted when full" : "R2 sequential store ready");
    end
    go_idle();
    wait_empty("R9 table");
    check("R2 transfer count", rec_n, 5);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 4; w++) ed[w*32 +: 32] = 32'hA000_0100 + 32'(4*k + w);
      if (k == 3) ed[127:96] = 32'hBEEF_010F;
      check_tx(k, 14'h40 + 14'(k), 4'hF, ed, (k == 3) ? "R8 R5 merged block" : "R2 R5 merged block");
    end
    ed = '0; ed[31:0] = 32'hA000_0110;
    check_tx(4, 14'h44, 4'h1, ed, "R5 order trailing block");

    // R4: merging off, every store its own entry; fifth stalls
    merge_en = 1'b0;
    mem_ready = 1'b0;
    rec_n = 0;
    for (int i = 0; i < 16; i++) begin
      put(16'h0200 + 16'(i), 32'hC000_0200 + 32'(i), (i <= 4), (i < 4), 3, 1'b1,
          "R4 no-merge ready");
    end
    go_idle();
    wait_empty("R9 no-merge");
    check("R4 transfer count", rec_n, 16);
    for (int i = 0; i < 16; i++) begin
      ed = '0;
      ed[(i%4)*32 +: 32] = 32'hC000_0200 + 32'(i);
      check_tx(i, 14'h80 + 14'(i/4), 4'(1 << (i%4)), ed, "R4 R5 single-word transfer");
    end

    // R8: rewrite of a valid slot, memory open
    merge_en = 1'b1;
    mem_ready = 1'b1;
    rec_n = 0;
    put(16'h0301, 32'h1111_1111, 1'b0, 1'b1, 0, 1'b0, "R8");
    put(16'h0301, 32'h2222_2222, 1'b0, 1'b1, 0, 1'b0, "R8");
    put(16'h0302, 32'h3333_3333, 1'b0, 1'b1, 0, 1'b0, "R8");
    go_idle();
    wait_empty("R9 rewrite");
    check("R8 transfer count", rec_n, 1);
    ed = '0; ed[63:32] = 32'h2222_2222; ed[95:64] = 32'h3333_3333;
    check_tx(0, 14'hC0, 4'b0110, ed, "R8 last write wins");

    // R7: offered head accepts no merge; R6 hold; R9 not empty while pending
    mem_ready = 1'b0;
    rec_n = 0;
    put(16'h0400, 32'hD000_0000, 1'b0, 1'b1, 0, 1'b0, "R7");
    go_idle();
    repeat (2) @(negedge clk);
    #1;
    check("R7 head offered after idle", mem_valid, 1'b1);
    check("R9 not empty while pending", empty, 1'b0);
    put(16'h0401, 32'hD000_0001, 1'b1, 1'b1, 0, 1'b0, "R7 store to offered block accepted");
    go_idle();
    repeat (2) @(negedge clk);
    #1;
    check("R6 R7 offered address held", mem_addr, 14'h100);
    check("R7 offered mask untouched", mem_mask, 4'b0001);
    mem_ready = 1'b1;
    wait_empty("R9 locked head");
    check("R7 transfer count", rec_n, 2);
    ed = '0; ed[31:0] = 32'hD000_0000;
    check_tx(0, 14'h100, 4'b0001, ed, "R7 first transfer");
    ed = '0; ed[63:32] = 32'hD000_0001;
    check_tx(1, 14'h100, 4'b0010, ed, "R7 second transfer");

    // retire and merge on the same edge: memory open during a sequential stream
    rec_n = 0;
    for (int i = 0; i < 16; i++)
      put(16'h0500 + 16'(i), 32'hE000_0500 + 32'(i), 1'b1, 1'b1, 0, 1'b0, "R2 streaming store ready");
    go_idle();
    wait_empty("R9 streaming");
    check("R2 streaming transfer count", rec_n, 4);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 4; w++) ed[w*32 +: 32] = 32'hE000_0500 + 32'(4*k + w);
      check_tx(k, 14'h140 + 14'(k), 4'hF, ed, "R2 R5 streaming block");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule